// File: doc/BRIEF.md
# Serial PHY Management Controller

This block runs clause-22 management transactions on an MDC/MDIO pair under the control of a small register set. Software programs a divider select, a PHY number and a register number, and for writes the 16-bit data word. It then sets the go bit in the command register. The controller shifts out a complete 64-bit frame while a busy flag stays set. Software polls the flag and, for a read, collects the PHY's answer from the read-data register.

MDC is generated from the system clock. Its half-period is programmable, and the line rests low between transactions. Outgoing bits change while MDC is low and the PHY samples them on the rising edge. On a read, the controller releases the line from the turnaround onward and captures the sixteen returned bits on rising MDC edges. The go bit is level-stored and software clears it itself. Only a write that sets it while the controller is idle launches a frame.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status, read-data and configuration registers read 0, MDC is low and the MDIO output enable is low.
- R2: Registers are decoded from bus_addr[4:2] and read back through bus_rdata as follows. Offset 0x00 holds the divider select in bits 5:2. Offset 0x04 holds the PHY number in bits 12:8 and the register number in bits 4:0. Offset 0x08 is the command register, with go in bit 0 and write-operation in bit 1. Offset 0x0C holds the write data in bits 15:0. Offset 0x10 is the read-data register, read-only, in bits 15:0. Offset 0x14 is the status register, read-only, with busy in bit 0.
- R3: A bus write to the command register with bit 0 set while idle starts a transaction, and status bit 0 then reads 1 for exactly 128*H system clocks. A command write with bit 0 clear starts nothing.
- R4: The MDC half-period H is (sel+1)*2 system clocks, with sel latched at start. A frame has exactly 128 MDC edges, and MDC is low whenever no transaction runs.
- R5: The frame is sent most significant bit first, in this order:
  - 32 ones;
  - start bits 01;
  - opcode 10 for a read or 01 for a write;
  - the 5-bit PHY number;
  - the 5-bit register number;
  - turnaround 10 on a write;
  - 16 data bits.
- R6: On a write all 64 bits are driven (mdio_oe high). On a read the output is released from bit 46, the first turnaround bit, to the end. When idle the output is released.
- R7: On a read, mdio_i is sampled on the rising MDC edge of bits 48..63, and the result is placed in read-data bits 15:0, first sample as the most significant bit. Read data is cleared when any transaction starts.
- R8: The PHY number, register number, write data and operation are captured at start. Register writes during a transaction do not alter the frame.
- R9: A command write with bit 0 set while busy is ignored. No second frame follows, and busy ends at the time set by the first start.
- R10: mdio_o and mdio_oe change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach from the ports is a set of register writes that land in the middle of a running frame. These are a new address, new write data and a second go with the opposite operation. The stimulus issues all three right after a start and then checks three things: the captured frame still carries the original fields, the busy window keeps its original length, and no extra MDC edges appear. A bench PHY model counts rising MDC edges, records the driven bits and output enable at each one, and answers reads with a known word from bit 48. The divider is swept across several selects to cover the timing and the turnaround release.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int PRE_LEN   = 32;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int OFS_W     = 5;
  localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int FRAME_LEN = DATA_POS + DATA_W;

  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_CMD   = 3'd2,
    SEL_WDATA = 3'd3,
    SEL_RDATA = 3'd4,
    SEL_STAT  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regn;
    logic [DATA_W-1:0] data;
  } xfer_t;
endpackage

// File: rtl/mdio_mgmt_regs.sv
`timescale 1ns/1ps
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFS_W-1:0]  addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  output logic [31:0]       rdata,
  output logic [DIV_W-1:0]  div_sel,
  output xfer_t             req,
  output logic              start
);
  logic [DIV_W-1:0]  cfg_q, cfg_d;
  logic [PHY_W-1:0]  phy_q, phy_d;
  logic [REG_W-1:0]  regn_q, regn_d;
  logic [1:0]        cmd_q, cmd_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr[4:2]);

  always_comb begin
    cfg_d  = cfg_q;
    phy_d  = phy_q;
    regn_d = regn_q;
    cmd_d  = cmd_q;
    wd_d   = wd_q;
    if (we) begin
      case (sel)
        SEL_CFG:   cfg_d = wdata[DIV_W+1:2];
        SEL_ADDR:  begin phy_d = wdata[12:8]; regn_d = wdata[4:0]; end
        SEL_CMD:   cmd_d = wdata[1:0];
        SEL_WDATA: wd_d = wdata[DATA_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      phy_q  <= '0;
      regn_q <= '0;
      cmd_q  <= '0;
      wd_q   <= '0;
    end else begin
      cfg_q  <= cfg_d;
      phy_q  <= phy_d;
      regn_q <= regn_d;
      cmd_q  <= cmd_d;
      wd_q   <= wd_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_CFG:   rdata = {{(30-DIV_W){1'b0}}, cfg_q, 2'b00};
      SEL_ADDR:  rdata = {19'b0, phy_q, 3'b0, regn_q};
      SEL_CMD:   rdata = {30'b0, cmd_q};
      SEL_WDATA: rdata = {{(32-DATA_W){1'b0}}, wd_q};
      SEL_RDATA: rdata = {{(32-DATA_W){1'b0}}, result};
      SEL_STAT:  rdata = {31'b0, busy};
      default:   rdata = '0;
    endcase
  end

  assign start   = we && (sel == SEL_CMD) && wdata[0] && !busy;
  assign div_sel = cfg_q;
  assign req     = '{wr: wdata[1], phy: phy_q, regn: regn_q, data: wd_q};
endmodule

// File: rtl/mdio_mgmt_div.sv
`timescale 1ns/1ps
module mdio_mgmt_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_mgmt_eng.sv
`timescale 1ns/1ps
module mdio_mgmt_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_t             req,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic [DIV_W:0]    limit,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] result
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic                 busy_q, busy_d;
  logic                 mdc_q, mdc_d;
  logic                 wr_q, wr_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    res_q, res_d;
  logic [DIV_W:0]       lim_q, lim_d;

  always_comb begin
    busy_d = busy_q;
    mdc_d  = mdc_q;
    wr_d   = wr_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    res_d  = res_q;
    lim_d  = lim_q;
    if (start) begin
      busy_d = 1'b1;
      mdc_d  = 1'b0;
      idx_d  = '0;
      wr_d   = req.wr;
      res_d  = '0;
      lim_d  = {div_sel, 1'b1};
      sh_d   = {{PRE_LEN{1'b1}}, 2'b01, (req.wr ? 2'b01 : 2'b10),
                req.phy, req.regn, 2'b10, (req.wr ? req.data : {DATA_W{1'b0}})};
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (!wr_q && idx_q >= DATA_IDX) res_d = {res_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      res_q  <= '0;
      lim_q  <= '0;
    end else begin
      busy_q <= busy_d;
      mdc_q  <= mdc_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      res_q  <= res_d;
      lim_q  <= lim_d;
    end
  end

  assign busy    = busy_q;
  assign limit   = lim_q;
  assign mdc     = mdc_q;
  assign mdio_o  = busy_q & sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && (wr_q || idx_q < TA_IDX);
  assign result  = res_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              busy_w;
  logic              start_w;
  logic              tick_w;
  logic [DIV_W-1:0]  div_sel_w;
  logic [DIV_W:0]    limit_w;
  logic [DATA_W-1:0] result_w;
  xfer_t             req_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mdio_mgmt_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy_w), .result(result_w), .rdata(bus_rdata),
    .div_sel(div_sel_w), .req(req_w), .start(start_w)
  );

  mdio_mgmt_div #(.CW(DIV_W + 1)) u_div (
    .clk(clk), .rst_n(core_rst_n), .run(busy_w), .limit(limit_w), .tick(tick_w)
  );

  mdio_mgmt_eng #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(core_rst_n), .start(start_w), .req(req_w),
    .div_sel(div_sel_w), .tick(tick_w), .mdio_i(mdio_i), .busy(busy_w),
    .limit(limit_w), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .result(result_w)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  p_idle_mdc_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_rise_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  p_end_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);

  p_hold_while_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  localparam logic [4:0] A_CFG = 5'h00, A_ADDR = 5'h04, A_CMD = 5'h08,
                         A_WD = 5'h0C, A_RD = 5'h10, A_ST = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: counts rising MDC edges, records driven bits, answers reads
  int          rcnt = 0;
  int          base = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] resp = 16'h0;

  always @(posedge mdc) begin
    automatic int k = rcnt - base;
    if (k >= 0 && k < 64) begin
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
    end
    rcnt = rcnt + 1;
  end

  assign mdio_i = ((rcnt - base) >= 48 && (rcnt - base) < 64) ?
                  resp[63-(rcnt-base)] : 1'b1;

  // MDC edge timing
  longint t_last = 0;
  int     mdc_edges = 0;
  int     bad_half = 0;
  int     exp_half = 2;
  always @(mdc) begin
    if (mdc_edges > 0 && ($time - t_last) != longint'(exp_half * 4)) bad_half++;
    t_last = $time;
    mdc_edges++;
  end

  // output stability while MDC is high, observed between clock edges
  int   hi_viol = 0;
  logic p_mdc = 1'b0, p_o = 1'b0, p_oe = 1'b0;
  always @(negedge clk) begin
    if (mdc && p_mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) hi_viol++;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_frame(input int sel, input bit wr, input logic [4:0] phy,
                           input logic [4:0] regn, input logic [15:0] data,
                           input logic [15:0] answer, input bit disturb);
    logic [31:0] rv;
    logic [63:0] ef, em;
    longint t0, t1;
    int half;
    half = (sel + 1) * 2;
    bwrite(A_CFG, 32'(sel) << 2);
    bwrite(A_ADDR, {19'b0, phy, 3'b0, regn});
    bwrite(A_WD, {16'b0, data});
    resp = answer;
    base = rcnt;
    exp_half = half;
    mdc_edges = 0;
    bad_half = 0;
    cap_o = '0; cap_oe = '0;
    bwrite(A_CMD, {30'b0, wr, 1'b1});
    bus_addr = A_ST;
    #1 t0 = $time;
    if (disturb) begin
      bwrite(A_ADDR, {19'b0, ~phy, 3'b0, ~regn});
      bwrite(A_WD, {16'b0, ~data});
      bwrite(A_CMD, {30'b0, ~wr, 1'b1});
      bus_addr = A_ST;
      #1;
    end
    while (bus_rdata[0] == 1'b1) begin
      @(negedge clk);
      #1;
    end
    t1 = $time;
    check((t1 - t0) / 4 == longint'(128 * half), disturb ? "R9 busy length" : "R3 busy length",
          64'((t1 - t0) / 4), 64'(128 * half));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle mdc low", {62'b0, mdc, mdio_oe}, 64'd0);
    check(bad_half == 0 && mdc_edges == 128, "R4 half period",
          {32'(bad_half), 32'(mdc_edges)}, {32'd0, 32'd128});
    ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, regn, 2'b10,
          (wr ? data : 16'h0)};
    em = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    check(cap_oe == em, "R6 output enable pattern", cap_oe, em);
    check((cap_o & em) == (ef & em), disturb ? "R8 frame content" : "R5 frame content",
          cap_o & em, ef & em);
    bread(A_RD, rv);
    check(rv == (wr ? 32'h0 : {16'h0, answer}), "R7 read data", 64'(rv),
          wr ? 64'h0 : 64'(answer));
    if (disturb) begin
      bread(A_ADDR, rv);
      check(rv == {19'b0, ~phy, 3'b0, ~regn}, "R2 address readback", 64'(rv),
            64'({19'b0, ~phy, 3'b0, ~regn}));
    end
    bwrite(A_CMD, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bread(A_ST, rv);  check(rv == 0, "R1 status after reset", 64'(rv), 0);
    bread(A_RD, rv);  check(rv == 0, "R1 read data after reset", 64'(rv), 0);
    bread(A_CFG, rv); check(rv == 0, "R1 config after reset", 64'(rv), 0);
    check(mdc == 0 && mdio_oe == 0, "R1 pins after reset", {62'b0, mdc, mdio_oe}, 0);

    // R2 readback of writable registers
    bwrite(A_CFG, 32'h0000_003C);
    bread(A_CFG, rv); check(rv == 32'h3C, "R2 config readback", 64'(rv), 64'h3C);
    bwrite(A_ADDR, 32'hFFFF_FFFF);
    bread(A_ADDR, rv); check(rv == 32'h1F1F, "R2 address field positions", 64'(rv), 64'h1F1F);
    bwrite(A_WD, 32'hDEAD_BEEF);
    bread(A_WD, rv); check(rv == 32'hBEEF, "R2 write data readback", 64'(rv), 64'hBEEF);

    // R3 command without go bit starts nothing
    mdc_edges = 0;
    bwrite(A_CMD, 32'h2);
    bread(A_CMD, rv); check(rv == 32'h2, "R2 command readback", 64'(rv), 64'h2);
    repeat (40) @(negedge clk);
    bread(A_ST, rv);
    check(rv == 0 && mdc_edges == 0, "R3 no start without go",
          {32'(rv), 32'(mdc_edges)}, 0);
    bwrite(A_CMD, 32'h0);

    // divider sweep, both operations
    for (int s = 0; s < 4; s++) begin
      for (int op = 0; op < 2; op++) begin
        run_frame(s, op[0], 5'((s * 9 + op * 5 + 1) % 32), 5'((s * 13 + op * 3 + 7) % 32),
                  16'(16'h1357 * (s + 1) + op * 16'h0F0F), 16'(16'hC3A5 ^ (s * 16'h1111)), 1'b0);
      end
    end
    // boundary fields
    run_frame(15, 1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h8001, 1'b0);
    run_frame(2, 1'b1, 5'd0, 5'd0, 16'h0000, 16'h0000, 1'b0);
    run_frame(0, 1'b0, 5'd0, 5'd31, 16'h0000, 16'hFFFF, 1'b0);
    run_frame(1, 1'b1, 5'd31, 5'd0, 16'hFFFF, 16'h0000, 1'b0);
    // mid-frame register writes and a second go
    run_frame(1, 1'b1, 5'd10, 5'd21, 16'hA55A, 16'h0000, 1'b1);
    run_frame(2, 1'b0, 5'd5, 5'd17, 16'h0000, 16'h6E93, 1'b1);

    check(hi_viol == 0, "R10 outputs stable while mdc high", 64'(hi_viol), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule